// File: doc/BRIEF.md
# Debug Breakpoint and Watchpoint Hit Qualifier

This block sits between the address comparators of a debug unit and the logic that raises debug exceptions. The comparators report a raw hit strobe for each breakpoint slot and each watchpoint slot. The block decides, for every strobe, whether that hit counts in the current execution context. It keeps a control word for every slot and a 32-bit value word for every breakpoint slot. These are programmed through a simple write port.

A hit qualifies when all of these hold:
- its slot is enabled;
- the slot's security field accepts the current security state;
- the slot's privilege fields accept the current privilege level;
- debug is globally enabled and currently allowed.

A slot can also chain to a linked breakpoint slot that compares the current context identifier. That linked slot must fall inside a window set by a configuration input.

All slots are evaluated in parallel. The qualified hits are reduced to one registered match pulse for breakpoints and one for watchpoints. The pulse appears one clock after the strobe.

Top module: `dbg_point_match`

## Requirements
- R1: After reset both match outputs are low and every control and value register is zero, so every slot is disabled and raw hits produce no match.
- R2: A slot whose control bit 0 (enable) is clear never qualifies.
- R3: The control field at bits 15:14 selects the security states in which a slot can qualify:
  - 0 accepts either state;
  - 2 accepts only the secure state (`secure`=1);
  - 1 or 3 accept only the non-secure state.
- R4: The privilege check depends on the current privilege level:
  - at level 2 or 3, control bit 13 must be set;
  - at level 1, control bit 1 must be set;
  - at level 0, control bit 2 must be set.
- R5: A watchpoint hit is checked against privilege level 0 when `wp_user` is high, whatever `cur_el` is. Breakpoint hits always use `cur_el`.
- R6: No match is reported unless both `mon_dbg_en` and `dbg_allowed` are high.
- R7: When control bit 20 (link) is set, the linked breakpoint slot named in bits 19:16 must meet three conditions:
  - its number is at most `cfg_bp_last`;
  - its number is at least `cfg_bp_last` − `cfg_ctx_cnt`;
  - its own enable bit is set.
  Otherwise the hit fails.
- R8: A linked breakpoint slot passes only when all of these hold:
  - its bits 23:20 equal 3;
  - the current privilege level is 0 or 1;
  - `ctx_id` equals that slot's value register.
  Any other type fails.
- R9: Slots are checked in parallel. `bp_match` / `wp_match` is high in the cycle after a clock edge at which any breakpoint / watchpoint slot qualified, and low otherwise.
- R10: A write with `wr_en` high takes effect at the next clock edge and updates one register:
  - `wr_sel` 0 writes a breakpoint control word;
  - `wr_sel` 1 writes a breakpoint value word;
  - `wr_sel` 2 writes a watchpoint control word;
  - `wr_sel` 3 changes nothing;
  - a `wr_idx` beyond the slot count changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target array: 0 bp control, 1 bp value, 2 wp control, 3 none |
| wr_idx | input | 4 | Slot number written |
| wr_data | input | 32 | Write data |
| cfg_bp_last | input | 4 | Number of the highest implemented breakpoint slot |
| cfg_ctx_cnt | input | 4 | Count of context-capable slots below the highest |
| bp_hit | input | NUM_BP | Raw breakpoint hit strobes, one per slot |
| wp_hit | input | NUM_WP | Raw watchpoint hit strobes, one per slot |
| wp_user | input | 1 | Watchpoint access carried the unprivileged attribute |
| cur_el | input | 2 | Current privilege level 0..3 |
| secure | input | 1 | Current security state, 1 = secure |
| mon_dbg_en | input | 1 | Global monitor debug enable |
| dbg_allowed | input | 1 | Debug exceptions currently permitted |
| ctx_id | input | 32 | Current context identifier |
| bp_match | output | 1 | Registered breakpoint match pulse |
| wp_match | output | 1 | Registered watchpoint match pulse |

## Verification
The bench builds the block with six breakpoint slots and two watchpoint slots. It uses a highest-slot number of 5 and a context count of 2, so the link window spans slots 3 to 5. With these values, links can land below the window (slot 2), on a disabled slot inside it (slot 5), and beyond both the window and the array (slot 7). Raising the context count to 3 then shows slot 2 entering the window. Because there are two watchpoint slots, one can hold a plain privilege filter while the other carries a linked context check.

// File: rtl/dbg_point_pkg.sv
package dbg_point_pkg;

  localparam int CTRL_W = 24;

  typedef enum logic [1:0] {
    SEL_BP_CTRL = 2'd0,
    SEL_BP_VAL  = 2'd1,
    SEL_WP_CTRL = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;

  // Control word layout (bit positions are decoded by the qualifier)
  typedef struct packed {
    logic [2:0] type_hi;   // 23:21, upper part of the linked type
    logic       link_en;   // 20, also bit 0 of the linked type
    logic [3:0] lnk_slot;  // 19:16
    logic [1:0] sec;       // 15:14
    logic       hyp;       // 13
    logic [9:0] rsvd;      // 12:3
    logic [1:0] priv;      // 2:1
    logic       en;        // 0
  } ctrl_t;

  localparam logic [3:0] CTX_TYPE = 4'd3;

  function automatic logic sec_pass(input logic [1:0] fld, input logic is_sec);
    case (fld)
      2'd0:    sec_pass = 1'b1;
      2'd2:    sec_pass = is_sec;
      default: sec_pass = !is_sec;
    endcase
  endfunction

  function automatic logic priv_pass(input logic [1:0] el, input logic [1:0] pf,
                                     input logic hyp);
    case (el)
      2'd0:    priv_pass = pf[1];
      2'd1:    priv_pass = pf[0];
      default: priv_pass = hyp;
    endcase
  endfunction

endpackage

// File: rtl/dbg_ctrl_bank.sv
module dbg_ctrl_bank
  import dbg_point_pkg::*;
#(
  parameter int N       = 4,
  parameter bit HAS_VAL = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_ctrl,
  input  logic                       wr_val,
  input  logic [3:0]                 wr_idx,
  input  logic [31:0]                wr_data,
  output logic [N-1:0][CTRL_W-1:0]   ctrl_o,
  output logic [N-1:0][31:0]         val_o
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic              idx_hit;
    logic              ctrl_ce;
    logic [CTRL_W-1:0] ctrl_d;
    logic [CTRL_W-1:0] ctrl_q;

    assign idx_hit = (wr_idx == 4'(g));
    assign ctrl_ce = wr_ctrl && idx_hit;

    always_comb begin
      ctrl_d = ctrl_q;
      if (ctrl_ce) ctrl_d = wr_data[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o[g] = ctrl_q;

    if (HAS_VAL) begin : g_val
      logic        val_ce;
      logic [31:0] val_d;
      logic [31:0] val_q;

      assign val_ce = wr_val && idx_hit;

      always_comb begin
        val_d = val_q;
        if (val_ce) val_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
      end

      assign val_o[g] = val_q;
    end else begin : g_noval
      assign val_o[g] = '0;
    end
  end

  if (!HAS_VAL) begin : g_sink
    logic unused_wr;
    assign unused_wr = ^{wr_val, wr_data};
  end

endmodule

// File: rtl/dbg_link_eval.sv
module dbg_link_eval
  import dbg_point_pkg::*;
#(
  parameter int NUM_BP = 6
) (
  input  logic [3:0]                      lnk_slot,
  input  logic [NUM_BP-1:0][CTRL_W-1:0]   bp_ctrl,
  input  logic [NUM_BP-1:0][31:0]         bp_val,
  input  logic [3:0]                      cfg_bp_last,
  input  logic [3:0]                      cfg_ctx_cnt,
  input  logic [1:0]                      cur_el,
  input  logic [31:0]                     ctx_id,
  output logic                            link_ok
);

  ctrl_t       sel_c;
  logic [31:0] sel_v;
  logic        exists;
  logic        in_win;
  logic        type_ok;

  always_comb begin
    sel_c  = '0;
    sel_v  = '0;
    exists = 1'b0;
    for (int k = 0; k < NUM_BP; k++) begin
      if (lnk_slot == 4'(k)) begin
        sel_c  = ctrl_t'(bp_ctrl[k]);
        sel_v  = bp_val[k];
        exists = 1'b1;
      end
    end
  end

  // Window: last - ctx <= slot <= last, evaluated without going negative
  assign in_win = exists
               && ({1'b0, lnk_slot} <= {1'b0, cfg_bp_last})
               && (({1'b0, lnk_slot} + {1'b0, cfg_ctx_cnt}) >= {1'b0, cfg_bp_last});

  assign type_ok = ({sel_c.type_hi, sel_c.link_en} == CTX_TYPE);

  assign link_ok = in_win && sel_c.en && type_ok && (cur_el <= 2'd1)
                && (ctx_id == sel_v);

  logic unused_sel;
  assign unused_sel = ^{sel_c.lnk_slot, sel_c.sec, sel_c.hyp, sel_c.rsvd, sel_c.priv};

endmodule

// File: rtl/dbg_slot_qual.sv
module dbg_slot_qual
  import dbg_point_pkg::*;
#(
  parameter int N      = 4,
  parameter int NUM_BP = 6
) (
  input  logic [N-1:0]                    hit,
  input  logic [N-1:0][CTRL_W-1:0]        ctrl,
  input  logic [NUM_BP-1:0][CTRL_W-1:0]   bp_ctrl,
  input  logic [NUM_BP-1:0][31:0]         bp_val,
  input  logic [1:0]                      acc_el,
  input  logic [1:0]                      cur_el,
  input  logic                            secure,
  input  logic [3:0]                      cfg_bp_last,
  input  logic [3:0]                      cfg_ctx_cnt,
  input  logic [31:0]                     ctx_id,
  output logic [N-1:0]                    qual
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    ctrl_t c;
    logic  lk_ok;

    assign c = ctrl_t'(ctrl[g]);

    dbg_link_eval #(.NUM_BP(NUM_BP)) u_link (
      .lnk_slot    (c.lnk_slot),
      .bp_ctrl     (bp_ctrl),
      .bp_val      (bp_val),
      .cfg_bp_last (cfg_bp_last),
      .cfg_ctx_cnt (cfg_ctx_cnt),
      .cur_el      (cur_el),
      .ctx_id      (ctx_id),
      .link_ok     (lk_ok)
    );

    assign qual[g] = hit[g] && c.en
                  && sec_pass(c.sec, secure)
                  && priv_pass(acc_el, c.priv, c.hyp)
                  && (!c.link_en || lk_ok);

    logic unused_c;
    assign unused_c = ^{c.type_hi, c.rsvd};
  end

endmodule

// File: rtl/dbg_point_match.sv
module dbg_point_match
  import dbg_point_pkg::*;
#(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [3:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        cfg_bp_last,
  input  logic [3:0]        cfg_ctx_cnt,
  input  logic [NUM_BP-1:0] bp_hit,
  input  logic [NUM_WP-1:0] wp_hit,
  input  logic              wp_user,
  input  logic [1:0]        cur_el,
  input  logic              secure,
  input  logic              mon_dbg_en,
  input  logic              dbg_allowed,
  input  logic [31:0]       ctx_id,
  output logic              bp_match,
  output logic              wp_match
);

  logic [NUM_BP-1:0][CTRL_W-1:0] bp_ctrl;
  logic [NUM_BP-1:0][31:0]       bp_val;
  logic [NUM_WP-1:0][CTRL_W-1:0] wp_ctrl;
  logic [NUM_WP-1:0][31:0]       unused_wp_val;
  logic [NUM_BP-1:0]             bp_qual;
  logic [NUM_WP-1:0]             wp_qual;
  logic [NUM_BP-1:0]             bp_en_vec;
  logic [NUM_WP-1:0]             wp_en_vec;

  wr_sel_e sel;
  logic    wr_bp_ctrl, wr_bp_val, wr_wp_ctrl;
  logic    gate;
  logic [1:0] wp_el;
  logic    bp_d, wp_d, bp_q, wp_q;

  assign sel        = wr_sel_e'(wr_sel);
  assign wr_bp_ctrl = wr_en && (sel == SEL_BP_CTRL);
  assign wr_bp_val  = wr_en && (sel == SEL_BP_VAL);
  assign wr_wp_ctrl = wr_en && (sel == SEL_WP_CTRL);

  dbg_ctrl_bank #(.N(NUM_BP), .HAS_VAL(1'b1)) u_bp_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_bp_ctrl),
    .wr_val  (wr_bp_val),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ctrl_o  (bp_ctrl),
    .val_o   (bp_val)
  );

  dbg_ctrl_bank #(.N(NUM_WP), .HAS_VAL(1'b0)) u_wp_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_wp_ctrl),
    .wr_val  (1'b0),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ctrl_o  (wp_ctrl),
    .val_o   (unused_wp_val)
  );

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bpen
    assign bp_en_vec[g] = bp_ctrl[g][0];
  end
  for (genvar g = 0; g < NUM_WP; g++) begin : g_wpen
    assign wp_en_vec[g] = wp_ctrl[g][0];
  end

  assign wp_el = wp_user ? 2'd0 : cur_el;

  dbg_slot_qual #(.N(NUM_BP), .NUM_BP(NUM_BP)) u_bp_qual (
    .hit         (bp_hit),
    .ctrl        (bp_ctrl),
    .bp_ctrl     (bp_ctrl),
    .bp_val      (bp_val),
    .acc_el      (cur_el),
    .cur_el      (cur_el),
    .secure      (secure),
    .cfg_bp_last (cfg_bp_last),
    .cfg_ctx_cnt (cfg_ctx_cnt),
    .ctx_id      (ctx_id),
    .qual        (bp_qual)
  );

  dbg_slot_qual #(.N(NUM_WP), .NUM_BP(NUM_BP)) u_wp_qual (
    .hit         (wp_hit),
    .ctrl        (wp_ctrl),
    .bp_ctrl     (bp_ctrl),
    .bp_val      (bp_val),
    .acc_el      (wp_el),
    .cur_el      (cur_el),
    .secure      (secure),
    .cfg_bp_last (cfg_bp_last),
    .cfg_ctx_cnt (cfg_ctx_cnt),
    .ctx_id      (ctx_id),
    .qual        (wp_qual)
  );

  assign gate = mon_dbg_en && dbg_allowed;

  always_comb begin
    bp_d = gate && (|bp_qual);
    wp_d = gate && (|wp_qual);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q <= 1'b0;
      wp_q <= 1'b0;
    end else begin
      bp_q <= bp_d;
      wp_q <= wp_d;
    end
  end

  assign bp_match = bp_q;
  assign wp_match = wp_q;

endmodule

// File: rtl/dbg_point_match_chk.sv
module dbg_point_match_chk #(
  parameter int NUM_BP = 6,
  parameter int NUM_WP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mon_dbg_en,
  input logic              dbg_allowed,
  input logic [NUM_BP-1:0] bp_hit,
  input logic [NUM_WP-1:0] wp_hit,
  input logic [NUM_BP-1:0] bp_en_vec,
  input logic [NUM_WP-1:0] wp_en_vec,
  input logic              bp_match,
  input logic              wp_match
);

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !(mon_dbg_en && dbg_allowed) |=> (!bp_match && !wp_match)); // R6

  AST_BP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_hit == '0) |=> !bp_match); // R9

  AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_hit == '0) |=> !wp_match); // R9

  AST_BP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((bp_hit & bp_en_vec) == '0) |=> !bp_match); // R2

  AST_WP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((wp_hit & wp_en_vec) == '0) |=> !wp_match); // R2

endmodule

bind dbg_point_match dbg_point_match_chk #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mon_dbg_en  (mon_dbg_en),
  .dbg_allowed (dbg_allowed),
  .bp_hit      (bp_hit),
  .wp_hit      (wp_hit),
  .bp_en_vec   (bp_en_vec),
  .wp_en_vec   (wp_en_vec),
  .bp_match    (bp_match),
  .wp_match    (wp_match)
);

// File: tb/dbg_point_match_tb.sv
`timescale 1ns/1ps
module dbg_point_match_tb;

  localparam int NBP = 6;
  localparam int NWP = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [1:0]     wr_sel;
  logic [3:0]     wr_idx;
  logic [31:0]    wr_data;
  logic [3:0]     cfg_bp_last;
  logic [3:0]     cfg_ctx_cnt;
  logic [NBP-1:0] bp_hit;
  logic [NWP-1:0] wp_hit;
  logic           wp_user;
  logic [1:0]     cur_el;
  logic           secure;
  logic           mon_dbg_en;
  logic           dbg_allowed;
  logic [31:0]    ctx_id;
  logic           bp_match;
  logic           wp_match;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  e_bp;
    logic  e_wp;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk = ~clk;

  dbg_point_match #(.NUM_BP(NBP), .NUM_WP(NWP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg_bp_last(cfg_bp_last), .cfg_ctx_cnt(cfg_ctx_cnt),
    .bp_hit(bp_hit), .wp_hit(wp_hit), .wp_user(wp_user), .cur_el(cur_el),
    .secure(secure), .mon_dbg_en(mon_dbg_en), .dbg_allowed(dbg_allowed),
    .ctx_id(ctx_id), .bp_match(bp_match), .wp_match(wp_match)
  );

  function automatic logic [31:0] cw(bit en, bit [1:0] pr, bit hy, bit [1:0] sc,
                                     bit [3:0] ln, bit [3:0] ty);
    logic [31:0] w;
    w        = '0;
    w[0]     = en;
    w[2:1]   = pr;
    w[13]    = hy;
    w[15:14] = sc;
    w[19:16] = ln;
    w[23:20] = ty;
    return w;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: apply strobes for one cycle, push the expected outcome
  task automatic probe(input logic [NBP-1:0] b, input logic [NWP-1:0] w,
                       input logic eb, input logic ew, input string tag);
    exp_t it;
    @(negedge clk);
    bp_hit = b; wp_hit = w;
    it.e_bp = eb; it.e_wp = ew; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    bp_hit = '0; wp_hit = '0;
  endtask

  // Monitor: result of a probe is registered at the following edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (bp_match !== it.e_bp || wp_match !== it.e_wp) begin
          errors++;
          $display("FAIL %s: bp_match/wp_match actual %b/%b expected %b/%b",
                   it.tag, bp_match, wp_match, it.e_bp, it.e_wp);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_idx = '0; wr_data = '0;
    cfg_bp_last = 4'd5; cfg_ctx_cnt = 4'd2; bp_hit = '0; wp_hit = '0;
    wp_user = 1'b0; cur_el = 2'd1; secure = 1'b0; mon_dbg_en = 1'b1;
    dbg_allowed = 1'b1; ctx_id = '0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (bp_match !== 1'b0 || wp_match !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b/%b expected 0/0", bp_match, wp_match);
    end
    @(negedge clk);
    rst_n = 1'b1;

    probe('1, '1, 0, 0, "R1 all slots off after reset");

    wr(2'd0, 4'd0, cw(1, 2'b11, 0, 0, 0, 0));
    probe(6'b000001, 0, 1, 0, "R9 bp0 at level 1");
    cur_el = 2'd0; probe(6'b000001, 0, 1, 0, "R4 level 0 with bit2");
    cur_el = 2'd2; probe(6'b000001, 0, 0, 0, "R4 level 2 without hyp bit");
    cur_el = 2'd3; probe(6'b000001, 0, 0, 0, "R4 level 3 without hyp bit");
    wr(2'd0, 4'd0, cw(1, 2'b11, 1, 0, 0, 0));
    cur_el = 2'd2; probe(6'b000001, 0, 1, 0, "R4 level 2 with hyp bit");
    cur_el = 2'd3; probe(6'b000001, 0, 1, 0, "R4 level 3 with hyp bit");
    cur_el = 2'd1;

    wr(2'd0, 4'd1, cw(0, 2'b11, 1, 0, 0, 0));
    probe(6'b000010, 0, 0, 0, "R2 disabled slot");

    wr(2'd0, 4'd2, cw(1, 2'b11, 1, 2, 0, 0));
    secure = 1'b0; probe(6'b000100, 0, 0, 0, "R3 field 2 non-secure");
    secure = 1'b1; probe(6'b000100, 0, 1, 0, "R3 field 2 secure");
    wr(2'd0, 4'd2, cw(1, 2'b11, 1, 1, 0, 0));
    probe(6'b000100, 0, 0, 0, "R3 field 1 secure");
    secure = 1'b0; probe(6'b000100, 0, 1, 0, "R3 field 1 non-secure");
    wr(2'd0, 4'd2, cw(1, 2'b11, 1, 3, 0, 0));
    secure = 1'b1; probe(6'b000100, 0, 0, 0, "R3 field 3 secure");
    secure = 1'b0; probe(6'b000100, 0, 1, 0, "R3 field 3 non-secure");

    wr(2'd0, 4'd0, cw(1, 2'b01, 0, 0, 0, 0));
    probe(6'b000001, 0, 1, 0, "R4 bit1 level 1");
    cur_el = 2'd0; probe(6'b000001, 0, 0, 0, "R4 bit1 only at level 0");
    wr(2'd0, 4'd0, cw(1, 2'b10, 0, 0, 0, 0));
    probe(6'b000001, 0, 1, 0, "R4 bit2 level 0");
    cur_el = 2'd1; probe(6'b000001, 0, 0, 0, "R4 bit2 only at level 1");

    wr(2'd2, 4'd0, cw(1, 2'b10, 0, 0, 0, 0));
    probe(6'b000001, 2'b01, 0, 0, "R5 no user attribute");
    wp_user = 1'b1;
    probe(6'b000001, 2'b01, 0, 1, "R5 user attribute wp only");
    wp_user = 1'b0;

    wr(2'd0, 4'd0, cw(1, 2'b11, 1, 0, 0, 0));
    mon_dbg_en = 1'b0; probe(6'b000001, 0, 0, 0, "R6 monitor debug off");
    mon_dbg_en = 1'b1; dbg_allowed = 1'b0;
    probe(6'b000001, 0, 0, 0, "R6 debug not allowed");
    dbg_allowed = 1'b1; probe(6'b000001, 0, 1, 0, "R6 both on");

    wr(2'd3, 4'd0, 32'h0);
    probe(6'b000001, 0, 1, 0, "R10 select 3 writes nothing");
    wr(2'd0, 4'd8, 32'h0);
    probe(6'b000001, 0, 1, 0, "R10 index beyond slots ignored");

    wr(2'd1, 4'd3, 32'h1234_5678);
    wr(2'd0, 4'd3, cw(1, 2'b00, 0, 0, 0, 4'b0011));
    wr(2'd2, 4'd1, cw(1, 2'b11, 1, 0, 3, 4'b0001));
    ctx_id = 32'h1234_5678;
    probe(0, 2'b10, 0, 1, "R8 context match");
    ctx_id = 32'h1234_5679;
    probe(0, 2'b10, 0, 0, "R8 context mismatch");
    ctx_id = 32'h1234_5678;
    cur_el = 2'd2; probe(0, 2'b10, 0, 0, "R8 level above 1");
    cur_el = 2'd0; probe(0, 2'b10, 0, 1, "R8 level 0");
    cur_el = 2'd1;

    wr(2'd1, 4'd2, 32'h1234_5678);
    wr(2'd0, 4'd2, cw(1, 2'b00, 0, 0, 0, 4'b0011));
    wr(2'd2, 4'd1, cw(1, 2'b11, 1, 0, 2, 4'b0001));
    probe(0, 2'b10, 0, 0, "R7 link below window");
    cfg_ctx_cnt = 4'd3;
    probe(0, 2'b10, 0, 1, "R7 window widened");
    cfg_ctx_cnt = 4'd2;
    wr(2'd2, 4'd1, cw(1, 2'b11, 1, 0, 5, 4'b0001));
    probe(0, 2'b10, 0, 0, "R7 linked slot disabled");
    wr(2'd2, 4'd1, cw(1, 2'b11, 1, 0, 7, 4'b0001));
    probe(0, 2'b10, 0, 0, "R7 link above last");
    wr(2'd2, 4'd1, cw(1, 2'b11, 1, 0, 3, 4'b0001));
    wr(2'd0, 4'd3, cw(0, 2'b00, 0, 0, 0, 4'b0011));
    probe(0, 2'b10, 0, 0, "R7 linked enable clear");
    wr(2'd0, 4'd3, cw(1, 2'b00, 0, 0, 0, 4'b0101));
    probe(0, 2'b10, 0, 0, "R8 linked type 5");

    probe(6'b110010, 2'b11, 0, 0, "R9 hits on non-qualifying slots");
    probe(6'b110011, 2'b11, 1, 0, "R9 one qualifying among many");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule